// File: doc/BRIEF.md
# Cascaded MAC Filter Cell Array

A linear array of eight identical multiply-accumulate cells for FIR-style vector work on 8-bit samples and 8-bit coefficients. One data register, loaded under its own enable, is broadcast to every cell. Coefficients enter cell 0 and ripple from cell to cell. Each cell multiplies its current coefficient by the broadcast sample and adds the sign-extended product into a private 26-bit accumulator. The coefficient leaving the last cell is driven out with its sign-mode bit, so several arrays can be chained into a longer filter.

Each cell holds one coefficient register followed by three optional delay registers. A 2-bit decimation code picks how many of these sit in the ripple path of every cell, so that a coefficient takes 1, 2, 3 or 4 cycles per cell hop. This reduces the output rate by the same factor. The coefficient operand and the data operand each have their own signed/unsigned control. An accumulator clear loads the product instead of adding it, so a new dot product starts without a dead cycle. All eight accumulator values are exported side by side.

Top module: `mac_cell_array`

## Requirements
- R1: On each clock edge outside reset, the coefficient register of cell 0 loads `coef_in` when `coef_en` is 1 and loads zero when `coef_en` is 0.
- R2: The broadcast data register loads `data_in` on an edge where `data_en` is 1 and keeps its value on an edge where `data_en` is 0.
- R3: With decimation code D on `dec_sel` (0, 1, 2 or 3), a coefficient reaches the coefficient register of cell k exactly k*(D+1) edges after it reached cell 0.
- R4: On each edge outside reset, every cell adds to its accumulator the product of the coefficient and data register values held before that edge.
- R5: `coef_signed` = 1 treats the coefficient operand as two's complement (bit 7 is the sign), 0 as unsigned; `data_signed` does the same for the data operand, independently. The product is sign-extended to 26 bits.
- R6: On an edge where `acc_clr` is 1, each accumulator is loaded with the product instead of adding it.
- R7: Accumulation wraps modulo 2^26.
- R8: `coef_out` is the coefficient leaving cell 7; a coefficient loaded into cell 0 at edge E appears there after edge E+8*(D+1)-1. `coef_signed_out` follows `coef_signed`.
- R9: A synchronous reset (`rst` = 1 at an edge) clears the data register, all coefficient and delay registers and all accumulators.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| data_in | input | 8 | Sample broadcast to all cells |
| data_en | input | 1 | Load enable for the sample register |
| coef_in | input | 8 | Coefficient entering cell 0 |
| coef_en | input | 1 | Load enable for the coefficient; zero enters when low |
| coef_signed | input | 1 | 1: coefficients are two's complement |
| data_signed | input | 1 | 1: samples are two's complement |
| dec_sel | input | 2 | Extra coefficient delays per cell (0 to 3) |
| acc_clr | input | 1 | Load product instead of adding it |
| coef_out | output | 8 | Coefficient leaving cell 7, for chaining |
| coef_signed_out | output | 1 | Coefficient sign mode for the next array |
| acc_out | output | 208 | Accumulators, cell k at bits 26k+25..26k |

## Verification
A wrong coefficient or delay register shows up at `coef_out` after the full ripple latency of 8*(D+1) cycles, but far sooner at the accumulator of the cell that holds it: that accumulator departs from its expected value one edge after the bad coefficient is used. A wrong data register corrupts all eight accumulators on the next edge. An error in sign handling or wrap shows only with operands that have bit 7 set or after sums cross 2^26, so those patterns are driven on purpose, and every accumulator is compared on every cycle.

// File: rtl/mca_pkg.sv
package mca_pkg;

    // Operand interpretation for one multiply.
    typedef struct packed {
        logic coef_s;
        logic data_s;
    } sign_mode_t;

endpackage

// File: rtl/mca_coef_stage.sv
module mca_coef_stage #(
    parameter int W       = 8,
    parameter int MAX_DEC = 3,
    localparam int SEL_W  = $clog2(MAX_DEC + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [W-1:0]     cin,
    input  logic [SEL_W-1:0] sel,
    output logic [W-1:0]     first,
    output logic [W-1:0]     cout
);

    logic [MAX_DEC:0][W-1:0] pipe;

    always_ff @(posedge clk) begin
        pipe[0] <= rst ? '0 : cin;
    end

    for (genvar i = 1; i <= MAX_DEC; i++) begin : g_dly
        always_ff @(posedge clk) begin
            pipe[i] <= rst ? '0 : pipe[i-1];
        end
    end

    always_comb begin
        cout = pipe[MAX_DEC];
        for (int i = 0; i <= MAX_DEC; i++) begin
            if (sel == SEL_W'(i)) cout = pipe[i];
        end
    end

    assign first = pipe[0];

endmodule

// File: rtl/mca_mac.sv
module mca_mac
    import mca_pkg::*;
#(
    parameter int W     = 8,
    parameter int ACC_W = 26,
    localparam int PW   = 2 * W + 2,
    localparam int EXT  = ACC_W - PW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [W-1:0]     coef,
    input  logic [W-1:0]     data,
    input  sign_mode_t       mode,
    input  logic             clr,
    output logic [ACC_W-1:0] acc
);

    logic signed [W:0]    op_c;
    logic signed [W:0]    op_d;
    logic signed [PW-1:0] prod;
    logic [ACC_W-1:0]     prod_ext;
    logic [ACC_W-1:0]     acc_q;

    assign op_c     = {mode.coef_s & coef[W-1], coef};
    assign op_d     = {mode.data_s & data[W-1], data};
    assign prod     = op_c * op_d;
    assign prod_ext = {{EXT{prod[PW-1]}}, prod};

    always_ff @(posedge clk) begin
        if (rst)      acc_q <= '0;
        else if (clr) acc_q <= prod_ext;
        else          acc_q <= acc_q + prod_ext;
    end

    assign acc = acc_q;

endmodule

// File: rtl/mac_cell_array.sv
module mac_cell_array
    import mca_pkg::*;
#(
    parameter int NCELL   = 8,
    parameter int W       = 8,
    parameter int ACC_W   = 26,
    parameter int MAX_DEC = 3,
    localparam int SEL_W  = $clog2(MAX_DEC + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [W-1:0]           data_in,
    input  logic                   data_en,
    input  logic [W-1:0]           coef_in,
    input  logic                   coef_en,
    input  logic                   coef_signed,
    input  logic                   data_signed,
    input  logic [SEL_W-1:0]       dec_sel,
    input  logic                   acc_clr,
    output logic [W-1:0]           coef_out,
    output logic                   coef_signed_out,
    output logic [NCELL*ACC_W-1:0] acc_out
);

    logic [W-1:0]            data_q;
    logic [NCELL-1:0][W-1:0] first_coef;
    logic [NCELL-1:0][W-1:0] stage_out;
    sign_mode_t              mode;

    assign mode.coef_s = coef_signed;
    assign mode.data_s = data_signed;

    always_ff @(posedge clk) begin
        if (rst)          data_q <= '0;
        else if (data_en) data_q <= data_in;
    end

    for (genvar k = 0; k < NCELL; k++) begin : g_cell
        logic [W-1:0] stage_in;

        if (k == 0) begin : g_head
            assign stage_in = coef_en ? coef_in : '0;
        end else begin : g_link
            assign stage_in = stage_out[k-1];
        end

        mca_coef_stage #(.W(W), .MAX_DEC(MAX_DEC)) u_stage (
            .clk   (clk),
            .rst   (rst),
            .cin   (stage_in),
            .sel   (dec_sel),
            .first (first_coef[k]),
            .cout  (stage_out[k])
        );

        mca_mac #(.W(W), .ACC_W(ACC_W)) u_mac (
            .clk  (clk),
            .rst  (rst),
            .coef (first_coef[k]),
            .data (data_q),
            .mode (mode),
            .clr  (acc_clr),
            .acc  (acc_out[k*ACC_W +: ACC_W])
        );
    end

    assign coef_out        = stage_out[NCELL-1];
    assign coef_signed_out = coef_signed;

endmodule

// File: rtl/mca_checker.sv
module mca_checker #(
    parameter int NCELL = 8,
    parameter int W     = 8,
    parameter int ACC_W = 26
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   data_en,
    input logic                   coef_en,
    input logic                   acc_clr,
    input logic [W-1:0]           data_q,
    input logic [NCELL-1:0][W-1:0] first_coef,
    input logic [NCELL-1:0][W-1:0] stage_out,
    input logic [W-1:0]           coef_out,
    input logic [NCELL*ACC_W-1:0] acc_out
);

    // R9: reset leaves every accumulator and the cascade output at zero
    a_r9_reset_clears: assert property (@(posedge clk)
        rst |=> (acc_out == '0 && coef_out == '0));

    // R1: a disabled coefficient input feeds zero into cell 0
    a_r1_zero_fill: assert property (@(posedge clk) disable iff (rst)
        !coef_en |=> first_coef[0] == '0);

    // R2: the sample register keeps its value when not enabled
    a_r2_data_hold: assert property (@(posedge clk) disable iff (rst)
        !data_en |=> $stable(data_q));

    // R4: a zero sample adds nothing to any accumulator
    a_r4_zero_adds_nothing: assert property (@(posedge clk) disable iff (rst)
        (data_q == '0 && !acc_clr) |=> $stable(acc_out));

    // R6: clearing with a zero sample leaves all accumulators at zero
    a_r6_clear_loads: assert property (@(posedge clk) disable iff (rst)
        (data_q == '0 && acc_clr) |=> acc_out == '0);

    // R3: cell 1 takes what left cell 0 one edge earlier
    a_r3_hop: assert property (@(posedge clk) disable iff (rst)
        !rst |=> first_coef[1] == $past(stage_out[0]));

endmodule

bind mac_cell_array mca_checker #(.NCELL(NCELL), .W(W), .ACC_W(ACC_W)) u_mca_checker (
    .clk        (clk),
    .rst        (rst),
    .data_en    (data_en),
    .coef_en    (coef_en),
    .acc_clr    (acc_clr),
    .data_q     (data_q),
    .first_coef (first_coef),
    .stage_out  (stage_out),
    .coef_out   (coef_out),
    .acc_out    (acc_out)
);

// File: tb/test_mac_cell_array.sv
module test_mac_cell_array;

    localparam int NC = 8;
    localparam int AW = 26;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [7:0]     data_in = '0;
    logic           data_en = 1'b0;
    logic [7:0]     coef_in = '0;
    logic           coef_en = 1'b0;
    logic           coef_signed = 1'b0;
    logic           data_signed = 1'b0;
    logic [1:0]     dec_sel = '0;
    logic           acc_clr = 1'b0;
    logic [7:0]     coef_out;
    logic           coef_signed_out;
    logic [NC*AW-1:0] acc_out;

    always #4 clk = ~clk;

    mac_cell_array i_mac_cell_array (
        .clk             (clk),
        .rst             (rst),
        .data_in         (data_in),
        .data_en         (data_en),
        .coef_in         (coef_in),
        .coef_en         (coef_en),
        .coef_signed     (coef_signed),
        .data_signed     (data_signed),
        .dec_sel         (dec_sel),
        .acc_clr         (acc_clr),
        .coef_out        (coef_out),
        .coef_signed_out (coef_signed_out),
        .acc_out         (acc_out)
    );

    typedef struct {
        logic [NC*AW-1:0] accv;
        logic [7:0]       co;
        logic             cso;
        string            tag;
    } item_t;

    item_t  sb[$];
    int     checks = 0;
    int     fails  = 0;
    int     D      = 0;
    int     n      = 0;
    int     hist[0:2047];
    int     mx     = 0;
    longint macc[NC];
    bit     done   = 1'b0;

    function automatic int coef_at(int k);
        int j = n - k * (D + 1);
        return (j >= 1) ? hist[j] : 0;
    endfunction

    // Driver: apply one cycle of stimulus, predict the state after the edge.
    task automatic step(input bit r, input int c, input bit ce, input int d,
                        input bit de, input bit clr, input bit cs, input bit ds,
                        input string tag);
        item_t it;
        int    j;
        @(negedge clk);
        rst <= r; coef_in <= c[7:0]; coef_en <= ce; data_in <= d[7:0];
        data_en <= de; acc_clr <= clr; coef_signed <= cs; data_signed <= ds;
        dec_sel <= D[1:0];
        @(posedge clk);
        if (r) begin
            n = 0; mx = 0;
            for (int k = 0; k < NC; k++) macc[k] = 0;
        end else begin
            for (int k = 0; k < NC; k++) begin
                longint a, b, p;
                a = coef_at(k);
                if (cs && a >= 128) a = a - 256;
                b = mx;
                if (ds && b >= 128) b = b - 256;
                p = a * b;
                macc[k] = (clr ? p : macc[k] + p) & ((64'sd1 << AW) - 1);
            end
            n = n + 1;
            hist[n] = ce ? c : 0;
            if (de) mx = d;
        end
        for (int k = 0; k < NC; k++) it.accv[k*AW +: AW] = macc[k][AW-1:0];
        j = n - 8 * (D + 1) + 1;
        it.co  = (j >= 1) ? hist[j][7:0] : 8'd0;
        it.cso = cs;
        it.tag = tag;
        sb.push_back(it);
    endtask

    // Monitor: compare each prediction shortly after its edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                for (int k = 0; k < NC; k++) begin
                    checks++;
                    if (acc_out[k*AW +: AW] !== it.accv[k*AW +: AW]) begin
                        fails++;
                        $display("FAIL %s cell%0d acc got %h exp %h", it.tag, k,
                                 acc_out[k*AW +: AW], it.accv[k*AW +: AW]);
                    end
                end
                checks++;
                if (coef_out !== it.co) begin
                    fails++;
                    $display("FAIL R8 (%s) coef_out got %h exp %h", it.tag, coef_out, it.co);
                end
                checks++;
                if (coef_signed_out !== it.cso) begin
                    fails++;
                    $display("FAIL R8 coef_signed_out got %b exp %b", coef_signed_out, it.cso);
                end
            end
        end
    end

    task automatic do_reset(input int dec);
        D = dec;
        step(1, 0, 0, 0, 0, 0, 0, 0, "R9");
        step(1, 0, 0, 0, 0, 0, 0, 0, "R9");
    endtask

    initial begin
        // R9: reset state
        do_reset(0);
        // R4: plain unsigned accumulate, every cell sees its own coefficient
        for (int i = 0; i < 40; i++)
            step(0, $urandom_range(255), 1, $urandom_range(255), 1, 0, 0, 0, "R4");
        // R2: sample register holds while coefficients keep moving
        for (int i = 0; i < 12; i++)
            step(0, $urandom_range(255), 1, $urandom_range(255), 0, 0, 0, 0, "R2");
        // R1: disabled coefficient input feeds zeros into the chain
        for (int i = 0; i < 12; i++)
            step(0, $urandom_range(255), 0, $urandom_range(255), 1, 0, 0, 0, "R1");
        // R5: each sign mode on its own, then both
        for (int i = 0; i < 20; i++)
            step(0, $urandom_range(255), 1, $urandom_range(255), 1, 0, 1, 0, "R5");
        for (int i = 0; i < 20; i++)
            step(0, $urandom_range(255), 1, $urandom_range(255), 1, 0, 0, 1, "R5");
        for (int i = 0; i < 20; i++)
            step(0, 128 + $urandom_range(127), 1, $urandom_range(255), 1, 0, 1, 1, "R5");
        // R6: clear pulses restart every accumulator with the product
        for (int i = 0; i < 30; i++)
            step(0, $urandom_range(255), 1, $urandom_range(255), 1, (i % 7) == 3, 1, 1, "R6");
        // R3: each decimation code from a fresh reset
        for (int dec = 1; dec <= 3; dec++) begin
            do_reset(dec);
            for (int i = 0; i < 50; i++)
                step(0, $urandom_range(255), 1, $urandom_range(255), 1, 0, 0, 1, "R3");
        end
        // R7: sustained full-scale products cross 2^26 and wrap
        do_reset(0);
        for (int i = 0; i < 1100; i++)
            step(0, 255, 1, 255, 1, 0, 0, 0, "R7");
        // R7: negative sums wrap below zero
        for (int i = 0; i < 20; i++)
            step(0, 128, 1, 127, 1, i == 0, 1, 1, "R7");
        // R9: reset in the middle of activity
        do_reset(0);
        step(0, 0, 0, 0, 0, 0, 0, 0, "R9");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (200000) @(posedge clk);
                fails++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule